// File: doc/BRIEF.md
# Frame Scrubber Controller

This block sweeps a small configuration-style memory, one frame at a time, without stopping. For each frame it reads the data word and the frame's stored check word into local registers and then compares them. If the check word shows an upset, the block logs the frame index, the bit offset and the kind of upset in an event register. It also raises an error pin, which stays raised until software reads the event register.

When repair is enabled, the block corrects a single flipped bit or two flipped neighbouring bits and writes the repaired word back to memory. Any other pattern is reported as uncorrectable and the memory is left unchanged.

The sweep runs on scan ticks rather than on every clock. A select input sets the tick rate to one tick every 2^sel clocks, so the check rate can be slowed. The check words are computed outside the block and supplied through a read-only port that uses the same address as the frame memory.

Top module: `mem_frame_scrubber`

## Requirements
- R1: While reset is held, `frame_addr` is 0, `err_valid` is 0, `frame_we` is 0, and the error pin is inactive (push-pull mode: `err_oe`=1 and `err_out`=0).
- R2: Frames are visited in ascending order. The address goes from the last frame straight back to 0. A clean frame occupies exactly two scan ticks: one to load it and one to check it.
- R3: A scan tick occurs once every 2^`div_sel` clocks. With the default sizes, a clean frame therefore holds the address for 2·2^`div_sel` clocks.
- R4: The check word is {Pe, Po, Se[4:0], So[4:0]} from MSB to LSB.
  - Pe is the XOR of the data bits at even positions, and Po the XOR of the bits at odd positions.
  - Se is the XOR of (i+1) over the set bits at even positions i, and So the same over the set bits at odd positions.
  - A syndrome of zero (stored word XOR computed word) logs nothing. A nonzero syndrome logs an event with `err_frame` equal to the frame index.
- R5: A syndrome that names one bit is logged with `err_kind`=1 and `err_bit` equal to that bit's offset. Such a syndrome has only the even half (Pe=1, Po=0, So=0, Se=i+1 with i even) or only the odd half set.
- R6: A syndrome in which Pe=Po=1 and the two located bits are neighbours is logged with `err_kind`=2 and `err_bit` equal to the lower of the two offsets.
- R7: Every other nonzero syndrome is logged with `err_kind`=3 and `err_bit`=0, and it is never written back.
- R8: With `scrub_en`=1, a frame whose upset is kind 1 or 2 is rewritten one scan tick after its check. The write pulses `frame_we` for one clock, and `frame_wdata` is the stored word with the located bits inverted.
- R9: With `scrub_en`=0, correctable upsets are still logged, but `frame_we` never rises.
- R10: `err_valid` and the error pin stay set after the frame has been repaired. A one-clock `err_rd` clears `err_valid` at the next clock edge.
- R11: If a new event is logged in the same clock in which `err_rd` is high, the event takes precedence and `err_valid` stays 1.
- R12: With `od_mode`=1, `err_out` is always 0 and `err_oe` equals `err_valid`, so the pin is pulled low on an error and released otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scrub_en | input | 1 | Enables write-back of repaired frames |
| div_sel | input | 2 | Scan tick every 2^div_sel clocks |
| od_mode | input | 1 | Selects the open-drain behaviour of the error pin |
| frame_addr | output | 3 | Frame index for memory and check-word store |
| frame_rdata | input | 16 | Frame data at frame_addr, combinational read |
| frame_we | output | 1 | Write strobe for the repaired frame |
| frame_wdata | output | 16 | Repaired frame data |
| chk_rdata | input | 12 | Stored check word at frame_addr |
| err_rd | input | 1 | Read strobe for the event register; clears err_valid |
| err_out | output | 1 | Error pin value |
| err_oe | output | 1 | Error pin output enable |
| err_valid | output | 1 | Event register holds an unread event |
| err_frame | output | 3 | Frame index of the last event |
| err_bit | output | 4 | Bit offset of the last event |
| err_kind | output | 2 | 1 single, 2 adjacent pair, 3 uncorrectable |

## Verification
Two functions can fall in the same clock: logging a fresh event and software clearing the event register. The bench provokes the collision by holding `err_rd` high for the whole time that an upset frame is scanned. The logging edge then necessarily coincides with a read.

The collision is judged correct if `err_valid` is seen set, with the new kind, in the clock after logging, and is then cleared one clock later because the read is still held. The bench also checks that the write-back of a repaired frame does not clear the pending error.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_SINGLE = 2'd1,
        KIND_ADJ    = 2'd2,
        KIND_MULTI  = 2'd3
    } upset_kind_e;

    typedef enum logic [1:0] {
        PH_LOAD  = 2'd0,
        PH_CHECK = 2'd1,
        PH_FIX   = 2'd2
    } scan_phase_e;
endpackage

// File: rtl/scrub_check_gen.sv
module scrub_check_gen #(
    parameter int W  = 16,
    parameter int SW = $clog2(W + 1)
) (
    input  logic [W-1:0]  data_i,
    output logic          par_even_o,
    output logic          par_odd_o,
    output logic [SW-1:0] pos_even_o,
    output logic [SW-1:0] pos_odd_o
);
    // Split parity and position code: even and odd bit lanes are summed apart.
    always_comb begin
        par_even_o = 1'b0;
        par_odd_o  = 1'b0;
        pos_even_o = '0;
        pos_odd_o  = '0;
        for (int i = 0; i < W; i++) begin
            if (data_i[i]) begin
                if ((i % 2) == 0) begin
                    par_even_o = ~par_even_o;
                    pos_even_o = pos_even_o ^ SW'(i + 1);
                end else begin
                    par_odd_o = ~par_odd_o;
                    pos_odd_o = pos_odd_o ^ SW'(i + 1);
                end
            end
        end
    end
endmodule

// File: rtl/scrub_syndrome_dec.sv
module scrub_syndrome_dec
    import scrub_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = $clog2(W + 1),
    parameter int BW = $clog2(W)
) (
    input  logic          s_pe_i,
    input  logic          s_po_i,
    input  logic [SW-1:0] s_se_i,
    input  logic [SW-1:0] s_so_i,
    output upset_kind_e   kind_o,
    output logic [BW-1:0] bit_o,
    output logic [W-1:0]  mask_o
);
    logic          even_ok, odd_ok, neighbours;
    logic [SW-1:0] low_pos;

    always_comb begin
        // A located even bit has an odd position code; a located odd bit an even one.
        even_ok    = (s_se_i != '0) && (s_se_i <= SW'(W)) && s_se_i[0];
        odd_ok     = (s_so_i != '0) && (s_so_i <= SW'(W)) && !s_so_i[0];
        neighbours = (s_so_i == s_se_i + SW'(1)) || (s_se_i == s_so_i + SW'(1));
        low_pos    = (s_se_i < s_so_i) ? s_se_i : s_so_i;
        kind_o     = KIND_NONE;
        bit_o      = '0;
        mask_o     = '0;
        if (!s_pe_i && !s_po_i && (s_se_i == '0) && (s_so_i == '0)) begin
            kind_o = KIND_NONE;
        end else if (s_pe_i && !s_po_i && (s_so_i == '0) && even_ok) begin
            kind_o = KIND_SINGLE;
            bit_o  = BW'(s_se_i - SW'(1));
            mask_o = W'(1) << (s_se_i - SW'(1));
        end else if (s_po_i && !s_pe_i && (s_se_i == '0) && odd_ok) begin
            kind_o = KIND_SINGLE;
            bit_o  = BW'(s_so_i - SW'(1));
            mask_o = W'(1) << (s_so_i - SW'(1));
        end else if (s_pe_i && s_po_i && even_ok && odd_ok && neighbours) begin
            kind_o = KIND_ADJ;
            bit_o  = BW'(low_pos - SW'(1));
            mask_o = (W'(1) << (s_se_i - SW'(1))) | (W'(1) << (s_so_i - SW'(1)));
        end else begin
            kind_o = KIND_MULTI;
        end
    end
endmodule

// File: rtl/scrub_tick_div.sv
module scrub_tick_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick_o
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim = '0;
        for (int k = 0; k < CW; k++) begin
            if (k < int'(div_sel)) lim[k] = 1'b1;
        end
        // >= lets the counter recover at once when the ratio is lowered
        tick_o = (cnt_q >= lim);
        cnt_d  = tick_o ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mem_frame_scrubber.sv
module mem_frame_scrubber
    import scrub_pkg::*;
#(
    parameter int N_FRAMES  = 8,
    parameter int FRAME_W   = 16,
    parameter int DIV_SEL_W = 2,
    localparam int AW   = $clog2(N_FRAMES),
    localparam int BW   = $clog2(FRAME_W),
    localparam int SW   = $clog2(FRAME_W + 1),
    localparam int CK_W = 2 + 2 * SW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scrub_en,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 od_mode,
    output logic [AW-1:0]        frame_addr,
    input  logic [FRAME_W-1:0]   frame_rdata,
    output logic                 frame_we,
    output logic [FRAME_W-1:0]   frame_wdata,
    input  logic [CK_W-1:0]      chk_rdata,
    input  logic                 err_rd,
    output logic                 err_out,
    output logic                 err_oe,
    output logic                 err_valid,
    output logic [AW-1:0]        err_frame,
    output logic [BW-1:0]        err_bit,
    output logic [1:0]           err_kind
);
    typedef struct packed {
        scan_phase_e        ph;
        logic [AW-1:0]      addr;
        logic [FRAME_W-1:0] frame;
        logic [CK_W-1:0]    ck;
        logic [FRAME_W-1:0] fixed;
        logic               ev_v;
        logic [AW-1:0]      ev_frame;
        logic [BW-1:0]      ev_bit;
        upset_kind_e        ev_kind;
    } scan_st_t;

    scan_st_t st_d, st_q;

    logic               tick, log_now, we_now;
    logic [AW-1:0]      next_addr;
    logic               c_pe, c_po;
    logic [SW-1:0]      c_se, c_so;
    upset_kind_e        dec_kind;
    logic [BW-1:0]      dec_bit;
    logic [FRAME_W-1:0] dec_mask;

    scrub_tick_div #(.SEL_W(DIV_SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick_o(tick)
    );

    scrub_check_gen #(.W(FRAME_W), .SW(SW)) u_gen (
        .data_i(st_q.frame), .par_even_o(c_pe), .par_odd_o(c_po),
        .pos_even_o(c_se), .pos_odd_o(c_so)
    );

    // Syndrome = recomputed check word XOR stored check word {Pe, Po, Se, So}
    scrub_syndrome_dec #(.W(FRAME_W), .SW(SW), .BW(BW)) u_dec (
        .s_pe_i(c_pe ^ st_q.ck[CK_W-1]),
        .s_po_i(c_po ^ st_q.ck[CK_W-2]),
        .s_se_i(c_se ^ st_q.ck[2*SW-1:SW]),
        .s_so_i(c_so ^ st_q.ck[SW-1:0]),
        .kind_o(dec_kind), .bit_o(dec_bit), .mask_o(dec_mask)
    );

    always_comb begin
        st_d      = st_q;
        log_now   = 1'b0;
        we_now    = 1'b0;
        next_addr = (st_q.addr == AW'(N_FRAMES - 1)) ? '0 : st_q.addr + AW'(1);
        unique case (st_q.ph)
            PH_LOAD: if (tick) begin
                st_d.frame = frame_rdata;
                st_d.ck    = chk_rdata;
                st_d.ph    = PH_CHECK;
            end
            PH_CHECK: if (tick) begin
                log_now = (dec_kind != KIND_NONE);
                if (scrub_en && (dec_kind == KIND_SINGLE || dec_kind == KIND_ADJ)) begin
                    st_d.fixed = st_q.frame ^ dec_mask;
                    st_d.ph    = PH_FIX;
                end else begin
                    st_d.addr = next_addr;
                    st_d.ph   = PH_LOAD;
                end
            end
            PH_FIX: if (tick) begin
                we_now    = 1'b1;
                st_d.addr = next_addr;
                st_d.ph   = PH_LOAD;
            end
            default: st_d.ph = PH_LOAD;
        endcase
        if (err_rd) st_d.ev_v = 1'b0;
        // a fresh event outranks a read in the same clock
        if (log_now) begin
            st_d.ev_v     = 1'b1;
            st_d.ev_frame = st_q.addr;
            st_d.ev_bit   = dec_bit;
            st_d.ev_kind  = dec_kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_LOAD, ev_kind: KIND_NONE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_addr  = st_q.addr;
    assign frame_we    = we_now;
    assign frame_wdata = st_q.fixed;
    assign err_valid   = st_q.ev_v;
    assign err_frame   = st_q.ev_frame;
    assign err_bit     = st_q.ev_bit;
    assign err_kind    = st_q.ev_kind;
    assign err_out     = od_mode ? 1'b0 : st_q.ev_v;
    assign err_oe      = od_mode ? st_q.ev_v : 1'b1;

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_addr) |-> frame_addr ==
            (($past(frame_addr) == AW'(N_FRAMES - 1)) ? AW'(0) : $past(frame_addr) + AW'(1)));

    assert_no_uncorr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_CHECK && tick && dec_kind == KIND_MULTI) |=> !frame_we);

    assert_fix_weight_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_we |-> ($countones(frame_wdata ^ st_q.frame) == 1 ||
                      $countones(frame_wdata ^ st_q.frame) == 2));

    assert_noscrub_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!scrub_en && st_q.ph == PH_CHECK && tick) |=> !frame_we);

    assert_hold_until_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_valid) |-> $past(err_rd));

    assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        log_now |=> err_valid);

    assert_od_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        od_mode |-> !err_out);
endmodule

// File: tb/mem_frame_scrubber_bench.sv
module mem_frame_scrubber_bench;
    logic        clk = 1'b0;
    logic        rst_n, scrub_en, od_mode, err_rd;
    logic [1:0]  div_sel;
    logic [2:0]  frame_addr, err_frame;
    logic [15:0] frame_rdata, frame_wdata;
    logic        frame_we, err_out, err_oe, err_valid;
    logic [11:0] chk_rdata;
    logic [3:0]  err_bit;
    logic [1:0]  err_kind;

    logic [15:0] mem [8];
    logic        inj_go;
    logic [2:0]  inj_idx;
    logic [15:0] inj_mask;
    int          wr_count = 0;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [15:0] golden(int i);
        return 16'hA5C3 ^ 16'(i * 4951);
    endfunction

    function automatic logic [11:0] gen_ck(logic [15:0] d);
        logic pe = 1'b0, po = 1'b0;
        logic [4:0] se = '0, so = '0;
        for (int i = 0; i < 16; i++) begin
            if (d[i]) begin
                if ((i % 2) == 0) begin pe = ~pe; se = se ^ 5'(i + 1); end
                else              begin po = ~po; so = so ^ 5'(i + 1); end
            end
        end
        return {pe, po, se, so};
    endfunction

    assign frame_rdata = mem[frame_addr];
    assign chk_rdata   = gen_ck(golden(int'(frame_addr)));

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mem[i] <= golden(i);
        end else begin
            if (frame_we) mem[frame_addr] <= frame_wdata;
            if (inj_go)   mem[inj_idx] <= mem[inj_idx] ^ inj_mask;
        end
    end

    always @(posedge clk) if (frame_we) wr_count <= wr_count + 1;

    mem_frame_scrubber u_mem_frame_scrubber (
        .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .div_sel(div_sel),
        .od_mode(od_mode), .frame_addr(frame_addr), .frame_rdata(frame_rdata),
        .frame_we(frame_we), .frame_wdata(frame_wdata), .chk_rdata(chk_rdata),
        .err_rd(err_rd), .err_out(err_out), .err_oe(err_oe), .err_valid(err_valid),
        .err_frame(err_frame), .err_bit(err_bit), .err_kind(err_kind)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic inject(input int f, input logic [15:0] m);
        @(negedge clk);
        inj_idx = 3'(f); inj_mask = m; inj_go = 1'b1;
        @(negedge clk);
        inj_go = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        int c = 0;
        while (!err_valid && c < 100) begin @(negedge clk); c++; end
        seen = err_valid;
    endtask

    task automatic do_read();
        @(negedge clk); err_rd = 1'b1;
        @(negedge clk); err_rd = 1'b0;
    endtask

    task automatic wait_change(output int c);
        logic [2:0] p = frame_addr;
        c = 0;
        do begin @(negedge clk); c++; end while (frame_addr == p && c < 200);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 addr", 32'(frame_addr), 0);
        chk("R1 valid", 32'(err_valid), 0);
        chk("R1 we", 32'(frame_we), 0);
        chk("R1 pin", 32'({err_oe, err_out}), 32'b10);
        rst_n = 1'b1;
    endtask

    task automatic t_sweep();
        int changes = 0, wraps = 0, badstep = 0, baddwell = 0, dwell = 0, errs = 0;
        int w0 = wr_count;
        logic [2:0] prev = frame_addr;
        logic [2:0] nx;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            dwell++;
            if (err_valid) errs++;
            if (frame_addr != prev) begin
                changes++;
                nx = prev + 3'd1;
                if (frame_addr != nx) badstep++;
                if (prev == 3'd7) wraps++;
                if (changes > 1 && dwell != 2) baddwell++;
                dwell = 0;
                prev = frame_addr;
            end
        end
        chk("R2 step order", 32'(badstep), 0);
        chk("R2 wrap seen", 32'(wraps >= 2), 1);
        chk("R2 two-tick dwell", 32'(baddwell), 0);
        chk("R4 clean no event", 32'(errs), 0);
        chk("R4 clean no write", 32'(wr_count - w0), 0);
    endtask

    task automatic t_divider(input logic [1:0] sel, input int exp);
        int c;
        div_sel = sel;
        wait_change(c); wait_change(c); wait_change(c);
        chk("R3 tick interval", 32'(c), 32'(exp));
    endtask

    task automatic t_correctable(input int f, input logic [15:0] m,
                                 input int kind, input int bitpos, input string req);
        bit seen;
        inject(f, m);
        wait_valid(seen);
        chk({req, " logged"}, 32'(seen), 1);
        chk("R4 frame", 32'(err_frame), 32'(f));
        chk({req, " kind"}, 32'(err_kind), 32'(kind));
        chk({req, " bit"}, 32'(err_bit), 32'(bitpos));
        chk("R8 write strobe", 32'(frame_we), 1);
        chk("R8 write data", 32'(frame_wdata), 32'(golden(f)));
        repeat (40) @(negedge clk);
        chk("R8 memory repaired", 32'(mem[f]), 32'(golden(f)));
        chk("R10 still pending", 32'({err_valid, err_out}), 32'b11);
        do_read();
        chk("R10 cleared by read", 32'(err_valid), 0);
    endtask

    task automatic t_uncorrectable(input int f, input logic [15:0] m);
        bit seen;
        int w0;
        inject(f, m);
        wait_valid(seen);
        w0 = wr_count;
        chk("R7 logged", 32'(seen), 1);
        chk("R7 frame", 32'(err_frame), 32'(f));
        chk("R7 kind", 32'(err_kind), 3);
        chk("R7 bit", 32'(err_bit), 0);
        chk("R7 no strobe", 32'(frame_we), 0);
        repeat (40) @(negedge clk);
        chk("R7 no write", 32'(wr_count - w0), 0);
        chk("R7 memory untouched", 32'(mem[f]), 32'(golden(f) ^ m));
        inject(f, m);
        repeat (20) @(negedge clk);
        do_read();
        repeat (20) @(negedge clk);
        chk("R4 quiet after restore", 32'(err_valid), 0);
    endtask

    task automatic t_noscrub();
        bit seen;
        int w0 = wr_count;
        scrub_en = 1'b0;
        inject(2, 16'h0001);
        wait_valid(seen);
        chk("R9 logged", 32'(seen), 1);
        chk("R9 kind", 32'(err_kind), 1);
        chk("R9 bit", 32'(err_bit), 0);
        repeat (40) @(negedge clk);
        chk("R9 no write", 32'(wr_count - w0), 0);
        chk("R9 memory untouched", 32'(mem[2]), 32'(golden(2) ^ 16'h0001));
        inject(2, 16'h0001);
        scrub_en = 1'b1;
        repeat (20) @(negedge clk);
        do_read();
        repeat (20) @(negedge clk);
        chk("R9 quiet after restore", 32'(err_valid), 0);
    endtask

    task automatic t_open_drain();
        bit seen;
        od_mode = 1'b1;
        inject(4, 16'h0008);
        wait_valid(seen);
        chk("R12 pulled low", 32'({err_oe, err_out}), 32'b10);
        repeat (30) @(negedge clk);
        do_read();
        chk("R12 released", 32'({err_oe, err_out}), 32'b00);
        od_mode = 1'b0;
        #1;
        chk("R12 push-pull idle", 32'({err_oe, err_out}), 32'b10);
    endtask

    task automatic t_collision();
        bit seen;
        @(negedge clk);
        err_rd = 1'b1;
        inject(7, 16'h3000);
        wait_valid(seen);
        chk("R11 event beats read", 32'(seen), 1);
        chk("R6 kind in collision", 32'(err_kind), 2);
        chk("R6 lower bit in collision", 32'(err_bit), 12);
        @(negedge clk);
        chk("R11 held read clears next", 32'(err_valid), 0);
        err_rd = 1'b0;
        repeat (40) @(negedge clk);
        chk("R11 memory repaired", 32'(mem[7]), 32'(golden(7)));
        chk("R11 no new event", 32'(err_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; scrub_en = 1'b1; div_sel = 2'd0; od_mode = 1'b0; err_rd = 1'b0;
        inj_go = 1'b0; inj_idx = '0; inj_mask = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_sweep();
        t_divider(2'd2, 8);
        t_divider(2'd1, 4);
        t_divider(2'd0, 2);
        t_correctable(3, 16'h0020, 1, 5, "R5 odd");
        t_correctable(0, 16'h8000, 1, 15, "R5 top");
        t_correctable(6, 16'h0600, 2, 9, "R6 even-high");
        t_correctable(1, 16'h0180, 2, 7, "R6 odd-low");
        t_uncorrectable(5, 16'h0014);
        t_uncorrectable(0, 16'h0012);
        t_noscrub();
        t_open_drain();
        t_collision();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule